// File: doc/BRIEF.md
# Bit-Atomic General-Purpose I/O Port

This block is a general-purpose I/O port that sits as a slave on a simple word-oriented register bus. It holds a direction mask and an output latch, and it gives firmware three ways to change the latch. A plain data write replaces the whole latch, so some pins can go high and others low in one access. A write to the set register raises only the bits written as one. A write to the clear register lowers only the bits written as one. The set and clear registers act on the latch itself, so software never has to read the port, modify the value and write it back. That saves a bus read and removes the race with other code that shares the port.

A read of the pin register gives a mixed view. Bits programmed as outputs return their latch value. Bits programmed as inputs return the external pin after a two-flop synchronizer. The external reset is asynchronous and active low. It asserts at once and is released on a clock edge.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset every direction bit is 0, the output latch is 0, `pins_oe` and `pins_out` are 0, and a read of the direction register at byte address 0x10 returns 0.
- R2: A write to byte address 0x18 (set) makes each latch bit whose write-data bit is 1 equal to 1. Every other latch bit keeps its value.
- R3: A write to byte address 0x1C (clear) makes each latch bit whose write-data bit is 1 equal to 0. Every other latch bit keeps its value.
- R4: A write to byte address 0x14 (pin data) loads the whole latch with the write data in one access.
- R5: A write to byte address 0x10 loads the direction register, where 1 means output. `pins_oe` equals the direction register. `pins_out` equals latch AND direction, so a pin set as an input drives 0.
- R6: A read at 0x14 returns the latch bit for each output pin and the synchronized input for each input pin. A change on `pins_in` becomes visible to reads after two rising clock edges and not after one.
- R7: Reads at 0x18 and 0x1C return 0. Reads of unmapped addresses return 0. Writes to unmapped addresses change neither the latch nor the direction register.
- R8: While `wr_en` is 0 no register changes, whatever the values on `addr` and `wdata`.
- R9: All register updates take effect on the rising clock edge that samples `wr_en` high, and appear on `pins_out` and `pins_oe` right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Byte address of the register being accessed |
| wr_en | input | 1 | Write strobe for the addressed register |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data for `addr`, combinational |
| pins_in | input | WIDTH | External pin levels, asynchronous |
| pins_oe | output | WIDTH | Per-pin output enable |
| pins_out | output | WIDTH | Per-pin output level |

## Verification
The hardest cases to reach are those where a set or clear write must leave untouched bits intact while the latch already holds a mix of ones and zeros. A single pattern proves little there. The bench therefore uses an 8-bit port. It loads several base latch patterns and applies every one of the 256 set masks and every one of the 256 clear masks to each base, then compares the result with the OR or AND-NOT of base and mask. The two-edge input latency is also hard to see from the ports. To reach it, the bench changes `pins_in` between edges and reads the pin register after one edge and again after two.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Byte offsets of the port registers
  localparam int unsigned OFS_DIR = 'h10;
  localparam int unsigned OFS_PIN = 'h14;
  localparam int unsigned OFS_SET = 'h18;
  localparam int unsigned OFS_CLR = 'h1C;

  typedef enum logic [2:0] {
    SEL_DIR,
    SEL_PIN,
    SEL_SET,
    SEL_CLR,
    SEL_NONE
  } gpio_sel_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = din;
    end else begin : g_rest
      always_comb stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_we,
  input  logic             load_we,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] lat_q
);

  logic [WIDTH-1:0] dir_d;
  logic [WIDTH-1:0] lat_d;
  logic             lat_en;

  always_comb begin
    dir_d  = dir_q;
    lat_d  = lat_q;
    lat_en = load_we | set_we | clr_we;
    if (dir_we)  dir_d = wdata;
    if (load_we) lat_d = wdata;
    if (set_we)  lat_d = lat_d | wdata;
    if (clr_we)  lat_d = lat_d & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lat_q <= '0;
    end else begin
      if (dir_we) dir_q <= dir_d;
      if (lat_en) lat_q <= lat_d;
    end
  end

  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> (((lat_q & $past(wdata)) == $past(wdata)) &&
                (((lat_q ^ $past(lat_q)) & ~$past(wdata)) == '0)));

  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> (((lat_q & $past(wdata)) == '0) &&
                (((lat_q ^ $past(lat_q)) & ~$past(wdata)) == '0)));

  // R4
  load_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> (lat_q == $past(wdata)));

  // R8
  hold_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_we || set_we || clr_we) |=> $stable(lat_q));

  // R8
  hold_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_we |=> $stable(dir_q));

endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  input  logic [WIDTH-1:0]  pins_in,
  output logic [WIDTH-1:0]  pins_oe,
  output logic [WIDTH-1:0]  pins_out
);

  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned RST_STAGES  = 2;

  logic             srst_n;
  gpio_sel_e        sel;
  logic             dir_we, load_we, set_we, clr_we;
  logic [WIDTH-1:0] dir_q, lat_q, in_sync, pin_view;

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .din   (pins_in),
    .dout  (in_sync)
  );

  always_comb begin
    if      (addr == ADDR_W'(OFS_DIR)) sel = SEL_DIR;
    else if (addr == ADDR_W'(OFS_PIN)) sel = SEL_PIN;
    else if (addr == ADDR_W'(OFS_SET)) sel = SEL_SET;
    else if (addr == ADDR_W'(OFS_CLR)) sel = SEL_CLR;
    else                               sel = SEL_NONE;
  end

  always_comb begin
    dir_we  = wr_en && (sel == SEL_DIR);
    load_we = wr_en && (sel == SEL_PIN);
    set_we  = wr_en && (sel == SEL_SET);
    clr_we  = wr_en && (sel == SEL_CLR);
  end

  gpio_out_latch #(.WIDTH(WIDTH)) u_latch (
    .clk     (clk),
    .rst_n   (srst_n),
    .dir_we  (dir_we),
    .load_we (load_we),
    .set_we  (set_we),
    .clr_we  (clr_we),
    .wdata   (wdata),
    .dir_q   (dir_q),
    .lat_q   (lat_q)
  );

  always_comb begin
    pin_view = (dir_q & lat_q) | (~dir_q & in_sync);
    unique case (sel)
      SEL_DIR: rdata = dir_q;
      SEL_PIN: rdata = pin_view;
      default: rdata = '0;
    endcase
  end

  assign pins_oe  = dir_q;
  assign pins_out = lat_q & dir_q;

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0({dir_we, load_we, set_we, clr_we}));

  // R7
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (sel == SEL_SET || sel == SEL_CLR || sel == SEL_NONE) |-> (rdata == '0));

  // R5
  input_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ((pins_out & ~pins_oe) == '0));

endmodule

// File: tb/sim_gpio_setclr_port.sv
module sim_gpio_setclr_port;

  localparam int W  = 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          wr_en;
  logic [W-1:0]  wdata, rdata, pins_in, pins_oe, pins_out;

  int total = 0;
  int bad   = 0;

  logic [W-1:0] m_dir, m_lat;

  always #4 clk = ~clk;

  gpio_setclr_port #(.WIDTH(W), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pins_in(pins_in), .pins_oe(pins_oe), .pins_out(pins_out)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic chk_outs(input string req);
    chk({req, " oe"}, pins_oe, m_dir);
    chk({req, " out"}, pins_out, m_lat & m_dir);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", total, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] r;
    logic [W-1:0] bases [4];
    bases[0] = 8'h00; bases[1] = 8'hFF; bases[2] = 8'h5A; bases[3] = 8'hC3;
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; wdata = '0; pins_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    m_dir = '0; m_lat = '0;
    chk("R1 oe", pins_oe, '0);
    chk("R1 out", pins_out, '0);
    rd(8'h10, r); chk("R1 dir read", r, '0);
    rd(8'h14, r); chk("R1 pin read", r, '0);

    // R5 latch loaded but all inputs: nothing driven
    wr(8'h14, 8'hFF); m_lat = 8'hFF;
    chk_outs("R5 inputs drive 0");
    rd(8'h14, r); chk("R6 input view", r, pins_in);

    // R5 direction sweep, R9 visible right after write edge
    for (int d = 0; d < 256; d++) begin
      wr(8'h10, W'(d)); m_dir = W'(d);
      chk_outs("R5 R9 dir sweep");
      rd(8'h10, r); chk("R5 dir read", r, W'(d));
    end

    // R4 full load sweep with all outputs
    wr(8'h10, 8'hFF); m_dir = 8'hFF;
    for (int v = 0; v < 256; v++) begin
      wr(8'h14, W'(v)); m_lat = W'(v);
      chk_outs("R4 load");
      rd(8'h14, r); chk("R4 R6 pin read", r, W'(v));
    end

    // R2 / R3 exhaustive masks over several bases
    for (int b = 0; b < 4; b++) begin
      for (int m = 0; m < 256; m++) begin
        wr(8'h14, bases[b]);
        wr(8'h18, W'(m)); m_lat = bases[b] | W'(m);
        chk_outs("R2 set");
        wr(8'h14, bases[b]);
        wr(8'h1C, W'(m)); m_lat = bases[b] & ~W'(m);
        chk_outs("R3 clear");
      end
    end

    // R7 write-only registers read zero, unmapped ignored
    wr(8'h14, 8'h96); m_lat = 8'h96;
    rd(8'h18, r); chk("R7 set reads 0", r, '0);
    rd(8'h1C, r); chk("R7 clr reads 0", r, '0);
    rd(8'h20, r); chk("R7 unmapped reads 0", r, '0);
    wr(8'h00, 8'h00); wr(8'h20, 8'hFF); wr(8'h15, 8'hFF); wr(8'h19, 8'hFF);
    chk_outs("R7 unmapped write");
    rd(8'h10, r); chk("R7 dir kept", r, m_dir);
    rd(8'h14, r); chk("R7 latch kept", r, 8'h96);

    // R8 no write strobe: nothing changes
    @(negedge clk);
    addr = 8'h18; wdata = 8'hFF; wr_en = 1'b0;
    @(negedge clk); addr = 8'h1C; @(negedge clk); addr = 8'h14;
    @(negedge clk); addr = 8'h10; wdata = 8'h00; @(negedge clk);
    chk_outs("R8 idle bus");

    // R6 mixed view and two-edge input latency
    wr(8'h10, 8'h0F); m_dir = 8'h0F;
    wr(8'h14, 8'hA5); m_lat = 8'hA5;
    pins_in = 8'h3C;
    @(negedge clk);
    rd(8'h14, r); chk("R6 one edge old", r, 8'h05);
    @(negedge clk);
    rd(8'h14, r); chk("R6 two edges new", r, (8'h0F & 8'hA5) | (8'hF0 & 8'h3C));
    pins_in = 8'hC3;
    @(negedge clk);
    rd(8'h14, r); chk("R6 one edge old", r, 8'h35);
    @(negedge clk);
    rd(8'h14, r); chk("R6 two edges new", r, (8'h0F & 8'hA5) | (8'hF0 & 8'hC3));

    // R1 reset again clears everything
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 async oe", pins_oe, '0);
    chk("R1 async out", pins_out, '0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(8'h10, r); chk("R1 dir after reset", r, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule